// File: doc/BRIEF.md
# Factored-Weight Voltage Beamformer

This block forms voltage beams for one frequency channel at a time. A channel strobe hands it one complex sample per antenna. For every beam it then adds up each antenna sample multiplied by a complex weight. It returns one complex result per beam, in ascending beam order. A dual-polarization beam is treated here as two separate single-polarization beams, so the beam count is the number of single-polarization beams.

No weight is stored per channel. Each weight is made on the fly from three factors. The first is a slowly varying complex instrumental gain. The second is an ionospheric phase, held as a lookup index. The third is a geometric phase that moves linearly across frequency. For every beam/antenna pair the geometric phase lives in a phase accumulator. A strobe marked as the first channel of a block loads it with a start value. Each later strobe adds a per-channel step to it. Coefficient writes go to shadow registers. They take effect only at the next block start, so one sum never mixes old and new coefficients.

The block does one multiply-accumulate per clock. It visits antennas in the inner loop and beams in the outer loop. While a sweep runs, it ignores new strobes.

Top module: `bf_beam_sum`

## Requirements
- R1: After an accepted strobe, the block emits one result per beam, in beam order 0 to NBEAM-1. Each result is Σn (s_n · w_{b,n}), with full-precision complex products and sums. beam_idx gives the beam number.
- R2: The weight is w = round(round(G · C(iono)) · C(geo)). Each complex product rounds each component as (x + 2^14) >>> 15 and then saturates it to the range -32768..32767. G is the instrumental gain, as signed Q1.15 components.
- R3: The lookup gives C(k) = (floor(32767·cos(2πk/256)+0.5), floor(32767·sin(2πk/256)+0.5)) for an 8-bit index k. The ionospheric term uses its stored index directly. The geometric term uses index ((phase + 128) mod 2^16) >> 8.
- R4: When a strobe with chan_first=1 is accepted, each geometric phase is set to its start value. Every accepted strobe with chan_first=0 adds the step, modulo 2^16. The sweep started by a strobe uses the phase as updated by that strobe.
- R5: cfg_we with cfg_kind writes only a shadow value for pair (cfg_beam, cfg_ant). The kinds are: 0 gain, with the real part in cfg_data[31:16] and the imaginary part in [15:0]; 1 ionospheric index, in [7:0]; 2 geometric start, in [15:0]; 3 geometric step, in [15:0]. The sums use the shadow values only after the next accepted strobe with chan_first=1.
- R6: busy is high for exactly NBEAM·NANT cycles after the edge that accepts a strobe. The result for beam k is valid for one cycle, starting (k+1)·NANT edges after the accepting edge.
- R7: A strobe that arrives while busy is high has no effect. It produces no output, it does not advance any phase, and it leaves the latched samples unchanged.
- R8: Reset clears busy and beam_vld, and sets every shadow value, active coefficient and phase to zero. A strobe after reset therefore gives all-zero results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_kind | input | 2 | Coefficient kind (see R5) |
| cfg_beam | input | $clog2(NBEAM) | Beam of the written coefficient |
| cfg_ant | input | $clog2(NANT) | Antenna of the written coefficient |
| cfg_data | input | 32 | Coefficient value |
| chan_go | input | 1 | Channel strobe; samples are taken with it |
| chan_first | input | 1 | Marks the strobe as the first channel of a block |
| ant_re | input | NANT·SW | Real sample parts, antenna n at bits [n·SW +: SW] |
| ant_im | input | NANT·SW | Imaginary sample parts, same packing |
| busy | output | 1 | Sweep in progress |
| beam_vld | output | 1 | Beam result valid |
| beam_idx | output | $clog2(NBEAM) | Beam number of the result |
| beam_re | output | SW+18+$clog2(NANT) | Real part of the beam sum |
| beam_im | output | SW+18+$clog2(NANT) | Imaginary part of the beam sum |

## Verification
The hardest situation to reach is a shadow write that lands in the middle of a block. Its effect must not show up until the following block start. The stimulus loads a fresh set of coefficients between two ordinary strobes and checks that those sums still use the old set. It then issues a block-start strobe and checks that the new set appears, with the phases restarted. A strobe is also sent during a running sweep. The next accepted channel then shows whether the phase advanced or the samples changed. Saturation of the weight is reached with full-scale gains at a 45-degree ionospheric phase. Phase wrap is reached with a large step over many channels.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int CW  = 16;
  localparam int GW  = 16;
  localparam int PHW = 8;

  typedef enum logic [1:0] {
    K_GAIN   = 2'd0,
    K_IONO   = 2'd1,
    K_GSTART = 2'd2,
    K_GSTEP  = 2'd3
  } coef_kind_e;

  typedef struct packed {
    logic signed [CW-1:0] re;
    logic signed [CW-1:0] im;
  } cq_t;

  // round to nearest (half up) from Q2.30 to Q1.15, then saturate
  function automatic logic signed [CW-1:0] cq_round(input logic signed [33:0] v);
    logic signed [33:0] t;
    t = (v + 34'sd16384) >>> 15;
    if (t > 34'sd32767)       return 16'sh7fff;
    else if (t < -34'sd32768) return 16'sh8000;
    else                      return t[CW-1:0];
  endfunction

  function automatic cq_t cq_mul(input cq_t a, input cq_t b);
    logic signed [33:0] pr, pi;
    cq_t r;
    pr = 34'($signed(a.re)) * 34'($signed(b.re)) - 34'($signed(a.im)) * 34'($signed(b.im));
    pi = 34'($signed(a.re)) * 34'($signed(b.im)) + 34'($signed(a.im)) * 34'($signed(b.re));
    r.re = cq_round(pr);
    r.im = cq_round(pi);
    return r;
  endfunction
endpackage

// File: rtl/bf_cis_lut.sv
module bf_cis_lut import bf_pkg::*; #(
  parameter int IW = PHW,
  localparam int TAB = 1 << IW
) (
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  output cq_t           cis_a,
  output cq_t           cis_b
);
  localparam real PI = 3.14159265358979323846;

  logic signed [CW-1:0] cos_t [TAB];
  logic signed [CW-1:0] sin_t [TAB];

  for (genvar k = 0; k < TAB; k++) begin : g_tab
    assign cos_t[k] = CW'($rtoi($floor(32767.0 * $cos(2.0 * PI * k / TAB) + 0.5)));
    assign sin_t[k] = CW'($rtoi($floor(32767.0 * $sin(2.0 * PI * k / TAB) + 0.5)));
  end

  assign cis_a.re = cos_t[idx_a];
  assign cis_a.im = sin_t[idx_a];
  assign cis_b.re = cos_t[idx_b];
  assign cis_b.im = sin_t[idx_b];
endmodule

// File: rtl/bf_coef_bank.sv
module bf_coef_bank import bf_pkg::*; #(
  parameter int NENT = 64,
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          commit,
  input  logic          advance,
  input  logic [IW-1:0] rd_idx,
  output cq_t           rd_gain,
  output logic [PHW-1:0] rd_iono,
  output logic [GW-1:0] rd_geo
);
  cq_t            sh_gain [NENT];
  logic [PHW-1:0] sh_iono [NENT];
  logic [GW-1:0]  sh_start[NENT];
  logic [GW-1:0]  sh_step [NENT];
  cq_t            ac_gain [NENT];
  logic [PHW-1:0] ac_iono [NENT];
  logic [GW-1:0]  ac_step [NENT];
  logic [GW-1:0]  phase   [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        sh_gain[i]  <= '0;
        sh_iono[i]  <= '0;
        sh_start[i] <= '0;
        sh_step[i]  <= '0;
        ac_gain[i]  <= '0;
        ac_iono[i]  <= '0;
        ac_step[i]  <= '0;
        phase[i]    <= '0;
      end
    end else begin
      if (commit) begin
        for (int i = 0; i < NENT; i++) begin
          ac_gain[i] <= sh_gain[i];
          ac_iono[i] <= sh_iono[i];
          ac_step[i] <= sh_step[i];
          phase[i]   <= sh_start[i];
        end
      end else if (advance) begin
        for (int i = 0; i < NENT; i++) phase[i] <= phase[i] + ac_step[i];
      end
      if (wr_en && int'(wr_idx) < NENT) begin
        case (coef_kind_e'(wr_kind))
          K_GAIN:   sh_gain[wr_idx]  <= wr_data;
          K_IONO:   sh_iono[wr_idx]  <= wr_data[PHW-1:0];
          K_GSTART: sh_start[wr_idx] <= wr_data[GW-1:0];
          default:  sh_step[wr_idx]  <= wr_data[GW-1:0];
        endcase
      end
    end
  end

  assign rd_gain = ac_gain[rd_idx];
  assign rd_iono = ac_iono[rd_idx];
  assign rd_geo  = phase[rd_idx];
endmodule

// File: rtl/bf_mac_seq.sv
module bf_mac_seq #(
  parameter int NANT = 16,
  parameter int NBEAM = 4,
  parameter int ACCW = 30,
  localparam int AW = $clog2(NANT),
  localparam int BW = $clog2(NBEAM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [ACCW-1:0] prod_re,
  input  logic signed [ACCW-1:0] prod_im,
  output logic                   busy,
  output logic [AW-1:0]          ant_cnt,
  output logic [BW-1:0]          beam_cnt,
  output logic                   out_vld,
  output logic [BW-1:0]          out_idx,
  output logic signed [ACCW-1:0] out_re,
  output logic signed [ACCW-1:0] out_im
);
  logic signed [ACCW-1:0] acc_re, acc_im, sum_re, sum_im;
  logic ant_last, beam_last;

  assign sum_re    = acc_re + prod_re;
  assign sum_im    = acc_im + prod_im;
  assign ant_last  = (ant_cnt == AW'(NANT - 1));
  assign beam_last = (beam_cnt == BW'(NBEAM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ant_cnt  <= '0;
      beam_cnt <= '0;
      acc_re   <= '0;
      acc_im   <= '0;
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_re   <= '0;
      out_im   <= '0;
    end else begin
      out_vld <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        ant_cnt  <= '0;
        beam_cnt <= '0;
        acc_re   <= '0;
        acc_im   <= '0;
      end else if (busy) begin
        if (ant_last) begin
          out_vld <= 1'b1;
          out_idx <= beam_cnt;
          out_re  <= sum_re;
          out_im  <= sum_im;
          acc_re  <= '0;
          acc_im  <= '0;
          ant_cnt <= '0;
          if (beam_last) busy <= 1'b0;
          else           beam_cnt <= beam_cnt + 1'b1;
        end else begin
          acc_re  <= sum_re;
          acc_im  <= sum_im;
          ant_cnt <= ant_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bf_beam_sum.sv
module bf_beam_sum import bf_pkg::*; #(
  parameter int NANT  = 16,
  parameter int NBEAM = 4,
  parameter int SW    = 8,
  localparam int AW   = $clog2(NANT),
  localparam int BW   = $clog2(NBEAM),
  localparam int ACCW = SW + CW + 2 + AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_kind,
  input  logic [BW-1:0]          cfg_beam,
  input  logic [AW-1:0]          cfg_ant,
  input  logic [31:0]            cfg_data,
  input  logic                   chan_go,
  input  logic                   chan_first,
  input  logic [NANT*SW-1:0]     ant_re,
  input  logic [NANT*SW-1:0]     ant_im,
  output logic                   busy,
  output logic                   beam_vld,
  output logic [BW-1:0]          beam_idx,
  output logic signed [ACCW-1:0] beam_re,
  output logic signed [ACCW-1:0] beam_im
);
  localparam int NENT = NANT * NBEAM;
  localparam int IW   = $clog2(NENT);
  localparam int HALF = 1 << (GW - PHW - 1);

  logic go_acc, commit, advance;
  logic [NANT*SW-1:0] smp_re, smp_im;
  logic [AW-1:0] ant_cnt;
  logic [BW-1:0] beam_cnt;
  logic [IW-1:0] wr_idx, rd_idx;
  cq_t gain, cis_io, cis_geo, w;
  logic [PHW-1:0] iono, geo_idx;
  logic [GW-1:0]  geo;
  logic signed [SW-1:0] sr, si;
  logic signed [ACCW-1:0] prod_re, prod_im;

  assign go_acc  = chan_go & ~busy;
  assign commit  = go_acc & chan_first;
  assign advance = go_acc & ~chan_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_re <= '0;
      smp_im <= '0;
    end else if (go_acc) begin
      smp_re <= ant_re;
      smp_im <= ant_im;
    end
  end

  assign wr_idx = IW'(cfg_beam * NANT) + IW'(cfg_ant);
  assign rd_idx = IW'(beam_cnt * NANT) + IW'(ant_cnt);

  bf_coef_bank #(.NENT(NENT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_kind(cfg_kind), .wr_idx(wr_idx), .wr_data(cfg_data),
    .commit(commit), .advance(advance), .rd_idx(rd_idx),
    .rd_gain(gain), .rd_iono(iono), .rd_geo(geo)
  );

  // nearest table entry for the geometric phase
  assign geo_idx = PHW'((geo + GW'(HALF)) >> (GW - PHW));

  bf_cis_lut #(.IW(PHW)) u_lut (
    .idx_a(iono), .idx_b(geo_idx), .cis_a(cis_io), .cis_b(cis_geo)
  );

  assign w  = cq_mul(cq_mul(gain, cis_io), cis_geo);
  assign sr = $signed(smp_re[ant_cnt*SW +: SW]);
  assign si = $signed(smp_im[ant_cnt*SW +: SW]);

  assign prod_re = ACCW'(sr) * ACCW'($signed(w.re)) - ACCW'(si) * ACCW'($signed(w.im));
  assign prod_im = ACCW'(sr) * ACCW'($signed(w.im)) + ACCW'(si) * ACCW'($signed(w.re));

  bf_mac_seq #(.NANT(NANT), .NBEAM(NBEAM), .ACCW(ACCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go_acc),
    .prod_re(prod_re), .prod_im(prod_im),
    .busy(busy), .ant_cnt(ant_cnt), .beam_cnt(beam_cnt),
    .out_vld(beam_vld), .out_idx(beam_idx), .out_re(beam_re), .out_im(beam_im)
  );
endmodule

// File: rtl/bf_beam_sum_chk.sv
module bf_beam_sum_chk #(
  parameter int NBEAM = 4,
  parameter int BW = 2,
  parameter int SMW = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go_acc,
  input logic           busy,
  input logic           beam_vld,
  input logic [BW-1:0]  beam_idx,
  input logic [SMW-1:0] smp_re,
  input logic [SMW-1:0] smp_im
);
  p_vld_in_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beam_vld |-> $past(busy));

  p_last_beam_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_vld && beam_idx == BW'(NBEAM - 1)) |-> !busy);

  p_go_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_acc |=> busy);

  p_hold_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(smp_re) && $stable(smp_im)));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!busy && !beam_vld));
endmodule

bind bf_beam_sum bf_beam_sum_chk #(.NBEAM(NBEAM), .BW(BW), .SMW(NANT*SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_acc(go_acc), .busy(busy),
  .beam_vld(beam_vld), .beam_idx(beam_idx), .smp_re(smp_re), .smp_im(smp_im)
);

// File: tb/bf_beam_sum_tb_top.sv
`timescale 1ns/1ps
module bf_beam_sum_tb_top;
  localparam int NA = 8;
  localparam int NB = 2;
  localparam int SW = 8;
  localparam int ACCW = SW + 16 + 2 + 3;
  localparam real PI = 3.14159265358979323846;

  logic clk = 0, rst_n;
  logic cfg_we = 0, chan_go = 0, chan_first = 0;
  logic [1:0] cfg_kind = 0;
  logic [0:0] cfg_beam = 0;
  logic [2:0] cfg_ant = 0;
  logic [31:0] cfg_data = 0;
  logic [NA*SW-1:0] ant_re = 0, ant_im = 0;
  logic busy, beam_vld;
  logic [0:0] beam_idx;
  logic signed [ACCW-1:0] beam_re, beam_im;

  always #5 clk = ~clk;

  bf_beam_sum #(.NANT(NA), .NBEAM(NB), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_beam(cfg_beam), .cfg_ant(cfg_ant), .cfg_data(cfg_data),
    .chan_go(chan_go), .chan_first(chan_first), .ant_re(ant_re), .ant_im(ant_im),
    .busy(busy), .beam_vld(beam_vld), .beam_idx(beam_idx),
    .beam_re(beam_re), .beam_im(beam_im)
  );

  int nvec = 0, nfail = 0;
  string cur_req = "R8";

  // reference state
  int sg_re[NB*NA], sg_im[NB*NA], s_io[NB*NA], s_st[NB*NA], s_in[NB*NA];
  int ag_re[NB*NA], ag_im[NB*NA], a_io[NB*NA], a_in[NB*NA], ph[NB*NA];
  int s_re[NA], s_im[NA];
  int cnt = 0, exp_idx = 0;
  bit exp_vld = 0;
  longint exp_re = 0, exp_im = 0;
  longint er[NB], ei[NB];

  function automatic longint rq(longint p);
    longint q;
    q = (p + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  function automatic void cis(int k, output longint c, output longint s);
    c = longint'($rtoi($floor(32767.0 * $cos(2.0 * PI * k / 256) + 0.5)));
    s = longint'($rtoi($floor(32767.0 * $sin(2.0 * PI * k / 256) + 0.5)));
  endfunction

  function automatic void weight(int i, output longint wr, output longint wi);
    longint c1, s1, c2, s2, tr, ti;
    cis(a_io[i], c1, s1);
    cis(((ph[i] + 128) & 16'hffff) >> 8, c2, s2);
    tr = rq(ag_re[i] * c1 - ag_im[i] * s1);
    ti = rq(ag_re[i] * s1 + ag_im[i] * c1);
    wr = rq(tr * c2 - ti * s2);
    wi = rq(tr * s2 + ti * c2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB*NA; i++) begin
        sg_re[i] = 0; sg_im[i] = 0; s_io[i] = 0; s_st[i] = 0; s_in[i] = 0;
        ag_re[i] = 0; ag_im[i] = 0; a_io[i] = 0; a_in[i] = 0; ph[i] = 0;
      end
      cnt = 0; exp_vld = 0;
    end else begin
      exp_vld = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt % NA == 0) begin
          exp_vld = 1;
          exp_idx = NB - 1 - cnt / NA;
          exp_re = er[exp_idx];
          exp_im = ei[exp_idx];
        end
      end else if (chan_go) begin
        for (int i = 0; i < NB*NA; i++) begin
          if (chan_first) begin
            ag_re[i] = sg_re[i]; ag_im[i] = sg_im[i]; a_io[i] = s_io[i];
            a_in[i] = s_in[i]; ph[i] = s_st[i];
          end else ph[i] = (ph[i] + a_in[i]) & 16'hffff;
        end
        for (int b = 0; b < NB; b++) begin
          er[b] = 0; ei[b] = 0;
          for (int a = 0; a < NA; a++) begin
            longint wr, wi;
            weight(b*NA + a, wr, wi);
            er[b] += s_re[a] * wr - s_im[a] * wi;
            ei[b] += s_re[a] * wi + s_im[a] * wr;
          end
        end
        cnt = NB * NA;
      end
      if (cfg_we) begin
        int i;
        i = cfg_beam * NA + cfg_ant;
        case (cfg_kind)
          2'd0: begin sg_re[i] = int'($signed(cfg_data[31:16])); sg_im[i] = int'($signed(cfg_data[15:0])); end
          2'd1: s_io[i] = cfg_data[7:0];
          2'd2: s_st[i] = cfg_data[15:0];
          default: s_in[i] = cfg_data[15:0];
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      nvec++;
      if (busy !== 1'b0 || beam_vld !== 1'b0) begin
        nfail++;
        $display("FAIL R8 reset: busy=%b vld=%b expected 0 0", busy, beam_vld);
      end
    end else begin
      nvec++;
      if (busy !== (cnt > 0) || beam_vld !== exp_vld) begin
        nfail++;
        $display("FAIL R6 timing: busy=%b vld=%b expected %b %b", busy, beam_vld, cnt > 0, exp_vld);
      end else if (exp_vld) begin
        nvec++;
        if (int'(beam_idx) != exp_idx || longint'(beam_re) != exp_re || longint'(beam_im) != exp_im) begin
          nfail++;
          $display("FAIL %s beam: idx=%0d re=%0d im=%0d expected %0d %0d %0d",
                   cur_req, beam_idx, longint'(beam_re), longint'(beam_im), exp_idx, exp_re, exp_im);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(int kind, int b, int a, logic [31:0] d);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_beam = 1'(b); cfg_ant = 3'(a); cfg_data = d;
    cyc();
    cfg_we = 0;
  endtask

  task automatic go(bit first, int mode);
    for (int a = 0; a < NA; a++) begin
      if (mode == 1) begin s_re[a] = -128; s_im[a] = -128; end
      else begin s_re[a] = int'($urandom_range(255)) - 128; s_im[a] = int'($urandom_range(255)) - 128; end
      ant_re[a*SW +: SW] = 8'(s_re[a]);
      ant_im[a*SW +: SW] = 8'(s_im[a]);
    end
    chan_go = 1; chan_first = first;
    cyc();
    chan_go = 0; chan_first = 0;
  endtask

  task automatic idle();
    while (cnt != 0) cyc();
    cyc();
  endtask

  task automatic load_random();
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < NA; a++) begin
        wr(0, b, a, $urandom);
        wr(1, b, a, 32'($urandom_range(255)));
        wr(2, b, a, 32'($urandom_range(65535)));
        wr(3, b, a, 32'($urandom_range(65535)));
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    cur_req = "R8"; go(0, 0); idle();          // zero coefficients after reset
    cur_req = "R1"; load_random(); go(1, 0); idle();
    cur_req = "R2"; go(0, 0); idle();
    cur_req = "R4"; for (int c = 0; c < 4; c++) begin go(0, 0); idle(); end
    cur_req = "R5"; load_random(); go(0, 0); idle(); go(0, 0); idle();
    cur_req = "R5"; go(1, 0); idle();          // shadow now committed
    cur_req = "R7"; go(0, 0); cyc(); cyc(); go(0, 0); idle(); go(0, 0); idle();
    cur_req = "R2";                            // saturating weight
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < NA; a++) begin
        wr(0, b, a, 32'h7fff7fff); wr(1, b, a, 32); wr(2, b, a, 0); wr(3, b, a, 0);
      end
    go(1, 1); idle(); go(0, 0); idle();
    cur_req = "R3";                            // phase rounding and wrap
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < NA; a++) begin
        wr(2, b, a, 32'hff00 + 32'(a*16)); wr(3, b, a, 32'h0f80 + 32'(b*32'h3333));
      end
    cur_req = "R4"; go(1, 0); idle();
    for (int c = 0; c < 20; c++) begin go(0, 0); idle(); end
    cur_req = "R1"; go(0, 0); go(0, 0); idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule